// File: doc/BRIEF.md
# Set/Clear-Enable Bitmap Interrupt Controller

This block collects up to 64 level-sensitive interrupt sources and raises one level request toward a processor. Each of its 64 channels picks a source through a byte-wide routing entry. The channel must then pass an enable layer and a mask layer before it counts as pending. Software sees the pending state as two 32-bit bitmaps, lower channels in the first word. It services the lowest set bit first and repeats until both words read zero.

Enable bits can be changed without a read-modify-write. One alias register sets every bit written as 1, and another clears every bit written as 1. A direct enable register replaces the whole half at once. The mask layer is a separate register pair, and a 1 in it blocks the channel. The register port is a plain single-cycle write strobe with a combinational read of the addressed word. It has no back-pressure: every strobe is accepted in the cycle it appears.

Top module: `sce_intc`

## Requirements
- R1: After reset all enable and mask bits are 0, channel n routes to source n, both status words read 0 and `irq_o` is low.
- R2: Status bit c (word 0x00 holds channels 31..0, word 0x04 holds 63..32) is 1 exactly when the source chosen by channel c's route entry is high, enable bit c is 1 and mask bit c is 0.
- R3: A write to 0x20 (channels 31..0) or 0x24 (channels 63..32) sets each enable bit whose data bit is 1.
- R4: A write to 0x30 (channels 31..0) or 0x34 (channels 63..32) clears each enable bit whose data bit is 1.
- R5: Data bits of 0 in a set or clear alias leave the enable bit unchanged. Reading 0x20/0x24 or 0x30/0x34 returns the current enable half.
- R6: A write to 0x40 (low half) or 0x44 (high half) replaces the enable half and reads back unchanged. Writing 0 to both disables every channel.
- R7: Mask registers sit at 0x50 (low) and 0x54 (high). A mask bit of 1 removes the channel from status and from `irq_o`. The mask changes only through writes to these offsets.
- R8: The routing table starts at 0x60. In the word at 0x60+i, byte k (bit 8k upward, least significant byte first) routes channel i+k. An entry value below 64 selects that source. A value of 64 or more makes the channel never active. Entries read back as written.
- R9: `irq_o` equals the OR of all status bits as they stood one clock earlier. It stays high while any status bit is set.
- R10: Writes to the status offsets 0x00/0x04 have no effect, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 64 | Level interrupt sources |
| reg_we | input | 1 | Register write strobe, taken at the rising edge |
| reg_addr | input | 8 | Byte offset of the word accessed, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
A register write takes effect at the rising edge that samples the strobe. Its result is visible through `reg_rdata` from the following falling edge, so the bench drives at a falling edge and reads back one full cycle later. Status words follow `src_i` combinationally, and they are sampled a couple of nanoseconds after the source changes. `irq_o` lags status by exactly one rising edge. The bench therefore checks it twice: right after a source change, when it must still hold its old value, and at the next falling edge, when it must hold the new one.

// File: rtl/sce_intc_pkg.sv
package sce_intc_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ROUTE_W = 8;

  // word offsets of the register map
  localparam logic [ADDR_W-1:0] OFF_STAT = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SET  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_CLR  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_EN   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_MSK  = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_RTE  = 8'h60;
endpackage

// File: rtl/sce_intc_regs.sv
module sce_intc_regs
  import sce_intc_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NSRC-1:0]      status,
  output logic [DATA_W-1:0]    rdata,
  output logic [NSRC-1:0]      en_q,
  output logic [NSRC-1:0]      msk_q,
  output logic [ROUTE_W-1:0]   route_q [NSRC]
);
  localparam int unsigned BPW     = DATA_W / ROUTE_W;      // route bytes per word
  localparam int unsigned RWORDS  = NSRC / BPW;            // words of routing table
  localparam int unsigned RTE_END = int'(OFF_RTE) + NSRC;  // first byte past the table

  logic [ADDR_W-1:0] grp;
  logic              hsel;
  logic              rte_hit;
  logic [ADDR_W-1:0] rte_off;
  logic [ADDR_W-3:0] rte_word;

  assign grp      = {addr[ADDR_W-1:3], 3'b000};
  assign hsel     = addr[2];
  assign rte_hit  = (addr[1:0] == 2'b00) && (int'(addr) >= int'(OFF_RTE)) && (int'(addr) < RTE_END);
  assign rte_off  = addr - OFF_RTE;
  assign rte_word = rte_off[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      msk_q <= '0;
      for (int c = 0; c < int'(NSRC); c++) route_q[c] <= ROUTE_W'(c);
    end else if (we) begin
      if (rte_hit) begin
        for (int k = 0; k < int'(BPW); k++)
          route_q[int'(rte_word) * int'(BPW) + k] <= wdata[8*k +: 8];
      end else if (addr[1:0] == 2'b00) begin
        unique case (grp)
          OFF_SET: en_q[32*hsel +: 32]  <= en_q[32*hsel +: 32] | wdata;
          OFF_CLR: en_q[32*hsel +: 32]  <= en_q[32*hsel +: 32] & ~wdata;
          OFF_EN:  en_q[32*hsel +: 32]  <= wdata;
          OFF_MSK: msk_q[32*hsel +: 32] <= wdata;
          default: ;
        endcase
      end
    end
  end

  logic [DATA_W-1:0] rte_rd;
  always_comb begin
    rte_rd = '0;
    for (int k = 0; k < int'(BPW); k++)
      if (int'(rte_word) < int'(RWORDS))
        rte_rd[8*k +: 8] = route_q[int'(rte_word) * int'(BPW) + k];
  end

  always_comb begin
    rdata = '0;
    if (rte_hit) begin
      rdata = rte_rd;
    end else if (addr[1:0] == 2'b00) begin
      unique case (grp)
        OFF_STAT:                rdata = status[32*hsel +: 32];
        OFF_SET, OFF_CLR, OFF_EN: rdata = en_q[32*hsel +: 32];
        OFF_MSK:                 rdata = msk_q[32*hsel +: 32];
        default:                 rdata = '0;
      endcase
    end
  end

  AST_SET_ONES: assert property (@(posedge clk) disable iff (rst)
    (we && addr == OFF_SET) |=> ((en_q[31:0] & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (rst)
    (we && addr == OFF_CLR) |=> ((en_q[31:0] & $past(wdata)) == '0)); // R4
  AST_ALIAS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (we && (addr == OFF_SET || addr == OFF_CLR))
      |=> (((en_q[31:0] ^ $past(en_q[31:0])) & ~$past(wdata)) == '0)); // R5
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && grp == OFF_MSK) |=> $stable(msk_q)); // R7
endmodule

// File: rtl/sce_intc_route.sv
module sce_intc_route
  import sce_intc_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      src,
  input  logic [NSRC-1:0]      en_q,
  input  logic [NSRC-1:0]      msk_q,
  input  logic [ROUTE_W-1:0]   route_q [NSRC],
  output logic [NSRC-1:0]      status
);
  localparam int unsigned IDX_W = $clog2(NSRC);

  logic [NSRC-1:0] chan_act;

  for (genvar c = 0; c < int'(NSRC); c++) begin : g_chan
    logic [IDX_W-1:0] sel;
    assign sel         = route_q[c][IDX_W-1:0];
    assign chan_act[c] = (int'(route_q[c]) < int'(NSRC)) ? src[sel] : 1'b0;
  end

  assign status = chan_act & en_q & ~msk_q;

  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst)
    ((status & ~(en_q & ~msk_q)) == '0)); // R2
endmodule

// File: rtl/sce_intc.sv
module sce_intc
  import sce_intc_pkg::*;
#(
  parameter int unsigned NSRC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NSRC-1:0]    en_q;
  logic [NSRC-1:0]    msk_q;
  logic [ROUTE_W-1:0] route_q [NSRC];
  logic [NSRC-1:0]    status;

  sce_intc_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .status(status), .rdata(reg_rdata), .en_q(en_q), .msk_q(msk_q), .route_q(route_q)
  );

  sce_intc_route #(.NSRC(NSRC)) u_route (
    .clk(clk), .rst(rst), .src(src_i), .en_q(en_q), .msk_q(msk_q),
    .route_q(route_q), .status(status)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |status;
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (|status) |=> irq_o); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |=> !irq_o); // R9
endmodule

// File: tb/tb_sce_intc.sv
module tb_sce_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] src_i = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sce_intc dut (
    .clk(clk), .rst(rst), .src_i(src_i), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;   // write data, or expected read data
    logic [63:0] src;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h40, 32'h0000_00F0, 64'h0, 4'd6},                   // R6 direct write
    '{1'b0, 8'h40, 32'h0000_00F0, 64'h0, 4'd6},                   // R6 read back
    '{1'b1, 8'h20, 32'h0000_0003, 64'h0, 4'd3},                   // R3 set bits 1:0
    '{1'b0, 8'h30, 32'h0000_00F3, 64'h0, 4'd5},                   // R5 alias reads enable
    '{1'b1, 8'h30, 32'h0000_0010, 64'h0, 4'd4},                   // R4 clear bit 4
    '{1'b0, 8'h20, 32'h0000_00E3, 64'h0, 4'd4},                   // R4 result
    '{1'b0, 8'h00, 32'h0000_00E3, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2}, // R2 status low
    '{1'b1, 8'h50, 32'h0000_0002, 64'h0, 4'd7},                   // R7 mask bit 1
    '{1'b0, 8'h00, 32'h0000_00E1, 64'hFFFF_FFFF_FFFF_FFFF, 4'd7}, // R7 masked out
    '{1'b1, 8'h24, 32'h8000_0001, 64'h0, 4'd3},                   // R3 high half
    '{1'b0, 8'h04, 32'h8000_0000, 64'h8000_0000_0000_0000, 4'd2}, // R2 status high
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 64'h8000_0000_0000_0000, 4'd10},// R10 write to status
    '{1'b0, 8'h04, 32'h8000_0000, 64'h8000_0000_0000_0000, 4'd10},// R10 unchanged
    '{1'b0, 8'h44, 32'h8000_0001, 64'h0, 4'd5},                   // R5 enable high
    '{1'b0, 8'h10, 32'h0000_0000, 64'h0, 4'd10}                   // R10 unmapped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2 d = reg_rdata;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h40, v); chk("R1 enable low", v, 32'h0);
    rd(8'h54, v); chk("R1 mask high", v, 32'h0);
    rd(8'h60, v); chk("R1 route word 0", v, 32'h0302_0100);
    rd(8'h9C, v); chk("R1 route word 15", v, 32'h3F3E_3D3C);
    src_i = '1;
    rd(8'h00, v); chk("R1 status low", v, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'h0);
    src_i = '0;

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_i = VEC[i].src;
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), v, VEC[i].data);
      end
    end

    // R6 zero both halves disables everything
    wr(8'h40, 32'h0); wr(8'h44, 32'h0);
    src_i = '1;
    rd(8'h00, v); chk("R6 status low after disable", v, 32'h0);
    rd(8'h04, v); chk("R6 status high after disable", v, 32'h0);
    @(negedge clk); chk("R6 irq after disable", {31'd0, irq_o}, 32'h0);
    src_i = '0;

    // R8 routing: ch0,2,3 -> source 5, ch1 -> out of range
    wr(8'h50, 32'h0);
    wr(8'h60, 32'h0505_FF05);
    wr(8'h40, 32'h0000_000F);
    rd(8'h60, v); chk("R8 route read back", v, 32'h0505_FF05);
    src_i = 64'h1;
    rd(8'h00, v); chk("R8 source 0 no longer on ch0", v, 32'h0);
    @(negedge clk); chk("R9 irq low with no status", {31'd0, irq_o}, 32'h0);
    src_i = 64'h20;
    #2 chk("R8 status from source 5", reg_rdata, 32'h0000_000D);
    chk("R9 irq not yet raised", {31'd0, irq_o}, 32'h0);
    @(negedge clk); chk("R9 irq one clock later", {31'd0, irq_o}, 32'h1);
    src_i = 64'h0;
    #2 chk("R9 irq held until edge", {31'd0, irq_o}, 32'h1);
    @(negedge clk); chk("R9 irq dropped", {31'd0, irq_o}, 32'h0);

    // R7 masked channels cannot raise irq
    wr(8'h50, 32'h0000_000F);
    src_i = 64'h20;
    @(negedge clk); @(negedge clk);
    chk("R7 irq stays low when masked", {31'd0, irq_o}, 32'h0);
    rd(8'h00, v); chk("R7 status masked", v, 32'h0);
    src_i = '0;

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule